// File: doc/BRIEF.md
# Threshold-Controlled SD Card Data FIFO

This block is the word buffer that sits between a register-mapped data port, through which software moves 32-bit words, and the card-side data engine that serialises them onto the card. It stores up to sixteen words in first-in, first-out order. It also carries the small amount of transfer bookkeeping that belongs next to the buffer: a byte counter that marks each finished block, a remaining-block counter that ends the transfer, and a four-bit engine state that tells software whether a transfer is running.

Software programs a block size in bytes and a block count, then starts a transfer in one of two directions. In a card-to-bus transfer the card side fills the buffer and software drains it. In a bus-to-card transfer software fills it and the card side drains it. A debug/control word gathers the engine state, the live fill level and two programmable thresholds. A data-available status bit compares the fill level, or the free space, against the threshold for the active direction, so software knows when a burst of reads or writes can proceed without stalling. Bus accesses that would overrun or underrun the buffer are dropped and leave a sticky error bit.

The card side uses valid/ready handshakes. A word moves on a cycle where both valid and ready are high. The FIFO holds `card_in_ready` low while it is full, and the producer must then keep its word and valid stable. The FIFO raises `card_out_valid` only while it holds a word, and the consumer may hold `card_out_ready` low for as long as it likes. The bus port has no handshake: every strobe is one access, and an access that cannot be served is counted as an error.

Top module: `sd_data_fifo`

## Requirements
- R1: The buffer holds 16 words of 32 bits and returns them in the order they were written. The fill level counts from 0 to 16.
- R2: `ctl_rdata` reports the engine state in bits 3:0, the fill level in bits 8:4, the write threshold in bits 13:9 and the read threshold in bits 18:14. All other bits read zero. After reset both thresholds are 4, the level is 0 and the state is 0 (identification). State 1 is data mode (idle), 2 is a card-to-bus transfer and 3 is a bus-to-card transfer.
- R3: `sts` bit 0 (data available) is high in state 2 when level >= read threshold, high in state 3 when (16 - level) >= write threshold, and low in every other state.
- R4: A bus write while the buffer is full, or during state 2, is dropped. A bus read while the buffer is empty, or during state 3, removes nothing. Either one sets the sticky error bit, `sts` bit 3, and leaves the level unchanged.
- R5: `card_in_ready` is high only in state 2 with level below 16. `card_out_valid` is high only in state 3 with level above 0. A word moves on each cycle where both valid and ready are high.
- R6: Each word moved on the card side adds 4 bytes to the byte counter. When the count reaches the programmed block size, the sticky block-done bit, `sts` bit 9, is set, the byte counter returns to zero and the remaining-block count drops by one.
- R7: When the remaining-block count reaches zero, the state returns to 1. A start with a block count of zero goes straight to state 1.
- R8: A control write with bit 19 set puts the engine in state 1 on the next cycle, aborts any transfer and keeps the buffer contents. The same write loads both thresholds from bits 13:9 and 18:14.
- R9: A status clear with mask bit 3 or bit 9 set clears the matching sticky bit. A set in the same cycle takes priority over the clear.
- R10: `xfer_start` is ignored while state 2 or 3 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Bus write strobe into the buffer |
| bus_wr_data | input | 32 | Bus write word |
| bus_rd_en | input | 1 | Bus read strobe (pops the head word) |
| bus_rd_data | output | 32 | Head word, valid before the pop |
| card_in_valid | input | 1 | Card side offers a word (state 2) |
| card_in_ready | output | 1 | Buffer accepts a card word |
| card_in_data | input | 32 | Card word into the buffer |
| card_out_valid | output | 1 | Buffer offers a word to the card (state 3) |
| card_out_ready | input | 1 | Card side takes the offered word |
| card_out_data | output | 32 | Head word toward the card |
| ctl_wr_en | input | 1 | Control/debug word write strobe |
| ctl_wdata | input | 32 | Control write value (thresholds, force bit 19) |
| ctl_rdata | output | 32 | State, level and thresholds |
| blk_bytes | input | 32 | Block size in bytes, latched at start |
| blk_count | input | 9 | Number of blocks, latched at start |
| xfer_start | input | 1 | Start pulse |
| xfer_dir | input | 1 | 1: card-to-bus, 0: bus-to-card |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 11 | Write-one-to-clear mask for status |
| sts | output | 11 | Status: bit 0 available, bit 3 error, bit 9 block done |

## Verification
The hardest condition to reach from the ports is a card producer that is stalled against a full buffer in the middle of a transfer and is then aborted. The stimulus first sets a two-block transfer of 64-byte blocks, so the sixteenth push does not end the transfer. It then holds `card_in_valid` high for several cycles against a deasserted ready and checks that the level stays at 16. It frees one slot to see ready return, and then issues the force write, which must leave the fifteen remaining words in place. The write-direction threshold is also reached on purpose: the bus preloads twelve words so that the free space sits just below the threshold, and one card pop must then raise the available bit.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [3:0] {
    ST_IDENT = 4'd0,
    ST_DATA  = 4'd1,
    ST_RX    = 4'd2,
    ST_TX    = 4'd3
  } eng_state_t;

  localparam int FLD_W     = 5;
  localparam int LVL_LSB   = 4;
  localparam int WTH_LSB   = 9;
  localparam int RTH_LSB   = 14;
  localparam int FORCE_BIT = 19;
  localparam int STS_W     = 11;
  localparam int STS_AVAIL = 0;
  localparam int STS_FERR  = 3;
  localparam int STS_BLK   = 9;
  localparam logic [FLD_W-1:0] THR_RESET = 5'd4;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  // R1: level bounded by capacity
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R1: level moves by at most one word per cycle
  assert_level_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (level == $past(level)) || (level == $past(level) + 1'b1) ||
    (level == $past(level) - 1'b1));
endmodule

// File: rtl/sdf_blk_ctr.sv
module sdf_blk_ctr #(
  parameter int BW         = 32,
  parameter int CW         = 9,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          abort,
  input  logic [BW-1:0] bytes_in,
  input  logic [CW-1:0] count_in,
  input  logic          word_tick,
  output logic          blk_done,
  output logic          xfer_end
);
  logic [BW-1:0] bytes_lat, byte_cnt;
  logic [CW-1:0] blks_left;
  logic [BW:0]   next_sum;

  assign next_sum = {1'b0, byte_cnt} + (BW + 1)'(WORD_BYTES);
  assign blk_done = word_tick && (blks_left != '0) && (next_sum >= {1'b0, bytes_lat});
  assign xfer_end = blk_done && (blks_left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_lat <= '0;
      byte_cnt  <= '0;
      blks_left <= '0;
    end else if (load) begin
      bytes_lat <= bytes_in;
      byte_cnt  <= '0;
      blks_left <= count_in;
    end else if (abort) begin
      byte_cnt  <= '0;
      blks_left <= '0;
    end else if (blk_done) begin
      byte_cnt  <= '0;
      blks_left <= blks_left - 1'b1;
    end else if (word_tick && blks_left != '0) begin
      byte_cnt  <= next_sum[BW-1:0];
    end
  end

  // R6: a finished block restarts the byte count
  assert_blk_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && !load |=> byte_cnt == '0);

  // R7: the last block leaves nothing outstanding
  assert_last_blk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end && !load |=> blks_left == '0);
endmodule

// File: rtl/sdf_ctl.sv
module sdf_ctl
  import sdf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [31:0]      ctl_wdata,
  input  logic             xfer_start,
  input  logic             xfer_dir,
  input  logic             count_zero,
  input  logic             xfer_end,
  input  logic             blk_done,
  input  logic             ferr_set,
  input  logic             sts_clr_en,
  input  logic [STS_W-1:0] sts_clr_mask,
  input  logic [LW-1:0]    level,
  output eng_state_t       state,
  output logic [FLD_W-1:0] rthr,
  output logic [FLD_W-1:0] wthr,
  output logic             start_ok,
  output logic             force_dm,
  output logic [STS_W-1:0] sts
);
  logic ferr_q, blk_q, avail, busy;
  logic [LW-1:0] free_words;
  logic unused_ctl_bits;

  assign unused_ctl_bits = ^{ctl_wdata[31:FORCE_BIT+1], ctl_wdata[WTH_LSB-1:0],
                             sts_clr_mask[STS_W-1:STS_BLK+1],
                             sts_clr_mask[STS_BLK-1:STS_FERR+1],
                             sts_clr_mask[STS_FERR-1:0]};

  assign busy       = (state == ST_RX) || (state == ST_TX);
  assign force_dm   = ctl_wr_en && ctl_wdata[FORCE_BIT];
  assign start_ok   = xfer_start && !busy && !force_dm;
  assign free_words = LW'(DEPTH) - level;

  always_comb begin
    unique case (state)
      ST_RX:   avail = (32'(level) >= 32'(rthr));
      ST_TX:   avail = (32'(free_words) >= 32'(wthr));
      default: avail = 1'b0;
    endcase
  end

  always_comb begin
    sts            = '0;
    sts[STS_AVAIL] = avail;
    sts[STS_FERR]  = ferr_q;
    sts[STS_BLK]   = blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDENT;
      rthr   <= THR_RESET;
      wthr   <= THR_RESET;
      ferr_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      if (ctl_wr_en) begin
        wthr <= ctl_wdata[WTH_LSB +: FLD_W];
        rthr <= ctl_wdata[RTH_LSB +: FLD_W];
      end
      if (force_dm)      state <= ST_DATA;
      else if (start_ok) state <= count_zero ? ST_DATA : (xfer_dir ? ST_RX : ST_TX);
      else if (xfer_end) state <= ST_DATA;

      if (ferr_set)                                ferr_q <= 1'b1;
      else if (sts_clr_en && sts_clr_mask[STS_FERR]) ferr_q <= 1'b0;
      if (blk_done)                                blk_q <= 1'b1;
      else if (sts_clr_en && sts_clr_mask[STS_BLK])  blk_q <= 1'b0;
    end
  end

  // R8: forcing data mode takes effect on the next cycle
  assert_force_dm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_dm |=> state == ST_DATA);

  // R4: the error bit stays set until cleared
  assert_ferr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q && !(sts_clr_en && sts_clr_mask[STS_FERR]) |=> ferr_q);

  // R10: a start during a transfer leaves the state alone
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && busy && !force_dm && !xfer_end |=> state == $past(state));
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
  import sdf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter int BYTES_W = 32,
  parameter int BLKS_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_en,
  input  logic [DATA_W-1:0]  bus_wr_data,
  input  logic               bus_rd_en,
  output logic [DATA_W-1:0]  bus_rd_data,
  input  logic               card_in_valid,
  output logic               card_in_ready,
  input  logic [DATA_W-1:0]  card_in_data,
  output logic               card_out_valid,
  input  logic               card_out_ready,
  output logic [DATA_W-1:0]  card_out_data,
  input  logic               ctl_wr_en,
  input  logic [31:0]        ctl_wdata,
  output logic [31:0]        ctl_rdata,
  input  logic [BYTES_W-1:0] blk_bytes,
  input  logic [BLKS_W-1:0]  blk_count,
  input  logic               xfer_start,
  input  logic               xfer_dir,
  input  logic               sts_clr_en,
  input  logic [STS_W-1:0]   sts_clr_mask,
  output logic [STS_W-1:0]   sts
);
  localparam int LW         = $clog2(DEPTH + 1);
  localparam int WORD_BYTES = DATA_W / 8;

  eng_state_t        state;
  logic [LW-1:0]     level;
  logic [FLD_W-1:0]  rthr, wthr;
  logic              full, empty, push, pop, in_rx, in_tx;
  logic              in_hs, out_hs, word_tick, ferr_set;
  logic              start_ok, force_dm, blk_done, xfer_end;
  logic [DATA_W-1:0] push_data, head;

  assign in_rx          = (state == ST_RX);
  assign in_tx          = (state == ST_TX);
  assign card_in_ready  = in_rx && !full;
  assign card_out_valid = in_tx && !empty;
  assign in_hs          = card_in_valid && card_in_ready;
  assign out_hs         = card_out_valid && card_out_ready;
  assign word_tick      = in_hs || out_hs;

  assign push      = in_rx ? in_hs : bus_wr_en;
  assign push_data = in_rx ? card_in_data : bus_wr_data;
  assign pop       = in_tx ? out_hs : bus_rd_en;
  assign ferr_set  = (bus_wr_en && (in_rx || full)) || (bus_rd_en && (in_tx || empty));

  assign bus_rd_data   = head;
  assign card_out_data = head;
  assign ctl_rdata     = {12'b0, 1'b0, rthr, wthr, FLD_W'(level), state};

  sdf_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .push, .push_data, .pop, .head, .level, .full, .empty
  );

  sdf_blk_ctr #(.BW(BYTES_W), .CW(BLKS_W), .WORD_BYTES(WORD_BYTES)) u_blk (
    .clk, .rst_n, .load(start_ok), .abort(force_dm), .bytes_in(blk_bytes),
    .count_in(blk_count), .word_tick, .blk_done, .xfer_end
  );

  sdf_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk, .rst_n, .ctl_wr_en, .ctl_wdata, .xfer_start, .xfer_dir,
    .count_zero(blk_count == '0), .xfer_end, .blk_done, .ferr_set,
    .sts_clr_en, .sts_clr_mask, .level, .state, .rthr, .wthr,
    .start_ok, .force_dm, .sts
  );

  // R5: an accepted card word without a pop raises the level by one
  assert_card_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_hs && !pop |=> level == $past(level) + 1'b1);

  // R4: a refused bus write leaves the level unchanged
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && full && !pop |=> level == $past(level));
endmodule

// File: tb/test_sd_data_fifo.sv
module test_sd_data_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 0, bus_rd_en = 0;
  logic [31:0] bus_wr_data = '0, bus_rd_data;
  logic        card_in_valid = 0, card_in_ready;
  logic [31:0] card_in_data = '0;
  logic        card_out_valid, card_out_ready = 0;
  logic [31:0] card_out_data;
  logic        ctl_wr_en = 0;
  logic [31:0] ctl_wdata = '0, ctl_rdata;
  logic [31:0] blk_bytes = '0;
  logic [8:0]  blk_count = '0;
  logic        xfer_start = 0, xfer_dir = 0, sts_clr_en = 0;
  logic [10:0] sts_clr_mask = '0, sts;
  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  sd_data_fifo i_sd_data_fifo (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] thr_word(input int r, input int w, input bit frc);
    return (32'(r) << 14) | (32'(w) << 9) | (32'(frc) << 19);
  endfunction

  task automatic bus_write(input logic [31:0] d);
    bus_wr_en = 1; bus_wr_data = d; @(negedge clk); bus_wr_en = 0;
  endtask
  task automatic bus_read(output logic [31:0] d);
    d = bus_rd_data; bus_rd_en = 1; @(negedge clk); bus_rd_en = 0;
  endtask
  task automatic ctl_write(input logic [31:0] d);
    ctl_wr_en = 1; ctl_wdata = d; @(negedge clk); ctl_wr_en = 0;
  endtask
  task automatic clr_sts(input logic [10:0] m);
    sts_clr_en = 1; sts_clr_mask = m; @(negedge clk); sts_clr_en = 0;
  endtask
  task automatic start(input bit dir, input logic [31:0] b, input logic [8:0] n);
    xfer_dir = dir; blk_bytes = b; blk_count = n; xfer_start = 1;
    @(negedge clk); xfer_start = 0;
  endtask
  task automatic card_push(input logic [31:0] d);
    card_in_valid = 1; card_in_data = d; @(negedge clk); card_in_valid = 0;
  endtask
  task automatic card_pop(output logic [31:0] d);
    d = card_out_data; card_out_ready = 1; @(negedge clk); card_out_ready = 0;
  endtask

  task automatic t_reset;
    chk("R2 reset control word", ctl_rdata, 32'h0001_0800);
    chk("R3 reset status", {21'b0, sts}, 32'h0);
    chk("R5 reset card ready", {31'b0, card_in_ready}, 32'h0);
  endtask

  task automatic t_over_under;
    for (int i = 0; i < 16; i++) bus_write(32'hC0DE_0000 + 32'(i));
    chk("R1 level full", {27'b0, ctl_rdata[8:4]}, 32'd16);
    chk("R4 no error yet", {31'b0, sts[3]}, 32'h0);
    bus_write(32'hDEAD_BEEF);
    chk("R4 overflow error", {31'b0, sts[3]}, 32'h1);
    chk("R4 overflow level kept", {27'b0, ctl_rdata[8:4]}, 32'd16);
    for (int i = 0; i < 16; i++) begin
      bus_read(rd);
      chk("R1 order", rd, 32'hC0DE_0000 + 32'(i));
    end
    clr_sts(11'h008);
    chk("R9 error cleared", {31'b0, sts[3]}, 32'h0);
    bus_read(rd);
    chk("R4 underflow error", {31'b0, sts[3]}, 32'h1);
    chk("R4 underflow level", {27'b0, ctl_rdata[8:4]}, 32'd0);
    clr_sts(11'h008);
  endtask

  task automatic t_zero_blocks;
    start(1'b1, 32'd8, 9'd0);
    chk("R7 zero-block start to data mode", {28'b0, ctl_rdata[3:0]}, 32'd1);
  endtask

  task automatic t_read_xfer;
    ctl_write(thr_word(3, 5, 0));
    chk("R2 thresholds loaded", ctl_rdata, 32'h0000_CA01);
    start(1'b1, 32'd8, 9'd2);
    chk("R2 state rx", {28'b0, ctl_rdata[3:0]}, 32'd2);
    chk("R3 rx below threshold", {31'b0, sts[0]}, 32'h0);
    chk("R5 ready in rx", {31'b0, card_in_ready}, 32'h1);
    card_push(32'hA000_0000);
    chk("R6 no block after one word", {31'b0, sts[9]}, 32'h0);
    card_push(32'hA000_0001);
    chk("R6 block done after 8 bytes", {31'b0, sts[9]}, 32'h1);
    clr_sts(11'h200);
    chk("R9 block bit cleared", {31'b0, sts[9]}, 32'h0);
    card_push(32'hA000_0002);
    chk("R3 rx at threshold", {31'b0, sts[0]}, 32'h1);
    start(1'b0, 32'd4, 9'd5);
    chk("R10 start ignored in rx", {28'b0, ctl_rdata[3:0]}, 32'd2);
    card_push(32'hA000_0003);
    chk("R7 transfer ended", {28'b0, ctl_rdata[3:0]}, 32'd1);
    chk("R6 second block done", {31'b0, sts[9]}, 32'h1);
    chk("R3 no avail outside transfer", {31'b0, sts[0]}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      bus_read(rd);
      chk("R1 rx order", rd, 32'hA000_0000 + 32'(i));
    end
    clr_sts(11'h208);
  endtask

  task automatic t_backpressure;
    start(1'b1, 32'd64, 9'd2);
    for (int i = 0; i < 16; i++) card_push(32'hB000_0000 + 32'(i));
    chk("R5 ready low when full", {31'b0, card_in_ready}, 32'h0);
    card_in_valid = 1; card_in_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    card_in_valid = 0;
    chk("R5 stalled level", {27'b0, ctl_rdata[8:4]}, 32'd16);
    chk("R5 no card out in rx", {31'b0, card_out_valid}, 32'h0);
    bus_read(rd);
    chk("R1 first rx word", rd, 32'hB000_0000);
    chk("R5 ready back", {31'b0, card_in_ready}, 32'h1);
    ctl_write(thr_word(3, 5, 1));
    chk("R8 forced data mode", {28'b0, ctl_rdata[3:0]}, 32'd1);
    chk("R8 contents kept", {27'b0, ctl_rdata[8:4]}, 32'd15);
    chk("R8 ready off after abort", {31'b0, card_in_ready}, 32'h0);
    for (int i = 1; i < 16; i++) begin
      bus_read(rd);
      chk("R8 kept word", rd, 32'hB000_0000 + 32'(i));
    end
    chk("R4 no error in clean drain", {31'b0, sts[3]}, 32'h0);
    clr_sts(11'h208);
  endtask

  task automatic t_write_xfer;
    for (int i = 0; i < 12; i++) bus_write(32'hE000_0000 + 32'(i));
    start(1'b0, 32'd4, 9'd3);
    chk("R2 state tx", {28'b0, ctl_rdata[3:0]}, 32'd3);
    chk("R3 tx free below threshold", {31'b0, sts[0]}, 32'h0);
    chk("R5 card out valid", {31'b0, card_out_valid}, 32'h1);
    chk("R5 no card in during tx", {31'b0, card_in_ready}, 32'h0);
    card_pop(rd);
    chk("R1 tx first word", rd, 32'hE000_0000);
    chk("R3 tx free at threshold", {31'b0, sts[0]}, 32'h1);
    chk("R6 one-word block", {31'b0, sts[9]}, 32'h1);
    for (int i = 1; i < 3; i++) begin
      card_pop(rd);
      chk("R1 tx order", rd, 32'hE000_0000 + 32'(i));
    end
    chk("R7 tx ended", {28'b0, ctl_rdata[3:0]}, 32'd1);
    chk("R7 tx level", {27'b0, ctl_rdata[8:4]}, 32'd9);
    chk("R5 out valid off after end", {31'b0, card_out_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_over_under();
    t_zero_blocks();
    t_read_xfer();
    t_backpressure();
    t_write_xfer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule